// File: doc/BRIEF.md
# Per-Instruction Stride Prefetcher for a First-Level Data Cache

This block watches the stream of loads entering a first-level data cache and learns, for each load instruction, the distance between the addresses it touches on successive executions. Learning is keyed by the instruction's program counter rather than by the address region. A loop that walks an array with a fixed step is therefore recognised even when other loads are interleaved with it. Each tracked instruction has one entry in a small direct-mapped table. The entry holds the instruction's full PC as a tag, the last byte address it loaded, the learned stride and a two-bit confidence state.

The prefetcher is deliberately timid. First-level capacity is small, and a wrong prefetch evicts data the program still needs. A request is made only when an instruction's pattern is confirmed, and never more than one line ahead. Each request takes a line fill buffer from a small pool that demand load misses and store misses also draw on. For that reason the block stays silent whenever the pool is close to empty. The requested line is reported one cycle after the load that triggered it, as a cache-line address (the byte address with the line offset removed).

Top module: `pfs_prefetcher`

## Requirements
- R1: After a synchronous active-low reset, `pf_valid` is low and every table entry is empty, so the first load of any PC after reset never triggers a prefetch.
- R2: The table has 16 entries indexed by PC bits [5:2]. A load whose PC differs from the stored tag (or that finds the entry empty) replaces the entry with a fresh one: last address = load address, stride = 0, state = initial. No prefetch is issued for that load. A PC evicted this way relearns from scratch.
- R3: Confidence moves as follows, where "match" means the new address minus the stored last address equals the stored stride. From initial, a match goes to steady and a mismatch goes to transient. From transient, a match goes to steady and a mismatch goes to no-prediction. From steady, a match stays in steady and a mismatch goes to initial. From no-prediction, a match goes to transient and a mismatch stays in no-prediction. On a mismatch the stored stride takes the new difference, except when leaving steady, where the stride is kept. The last address always takes the new address. A prefetch is considered only when the updated state is steady, so a constant nonzero stride first issues on the third load of a PC.
- R4: Entries train independently, so a stream keeps its pattern while loads from other PCs with different index bits interleave with it.
- R5: A single off-pattern address for a steady PC issues nothing. If the next load then matches the kept stride, that load issues again.
- R6: A learned stride of zero never issues a prefetch.
- R7: The target is the load address plus the stride, taken modulo 2^32 (a negative stride is two's complement). With 64-byte lines the target line is bits [31:6] of that sum. Nothing is issued when this line equals the line of the load itself.
- R8: A prefetch is issued only if `fb_free` is at least 3 plus `ld_miss`, so that a demand miss in the same cycle still leaves 3 buffers.
- R9: A target line equal to the most recently issued prefetch line is dropped. Only issued prefetches update this record, and reset clears it.
- R10: A load presented in cycle t yields `pf_valid` high for exactly one cycle after the clock edge that ends t, with `pf_line` holding the target line. Cycles without a load never produce a prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_pc | input | 32 | Program counter of the load instruction |
| ld_addr | input | 32 | Byte address of the load |
| ld_miss | input | 1 | The load missed and will take a fill buffer |
| fb_free | input | 4 | Number of line fill buffers currently free |
| pf_valid | output | 1 | Prefetch request valid (one cycle) |
| pf_line | output | 26 | Line address of the prefetch request |

## Verification
The bench goes after these corner cases:
- Two PCs that alias on the index bits. A design that matched on index alone would keep issuing for the wrong instruction after an eviction.
- A single break in a steady stream. A design that overwrote the stride when leaving steady would stay silent on the resumed pattern.
- Small strides that cross a line boundary only now and then. A design without the same-line check would issue prefetches for the load's own line.
- Two instructions walking the same array. A design without duplicate filtering would spend a fill buffer twice on one line.
- The fill-buffer budget at exactly 3 free buffers, with and without a concurrent miss. An off-by-one in the budget check would either starve demand misses or never issue.

// File: rtl/pfs_pkg.sv
// Package: shared types for the per-instruction stride prefetcher.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package pfs_pkg;

    // Two-bit confidence of one table entry.
    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_TRANS  = 2'd1,
        ST_STEADY = 2'd2,
        ST_NOPRED = 2'd3
    } conf_e;

endpackage

// File: rtl/pfs_table.sv
// Module: direct-mapped training table.
// Holds per entry a valid bit, full PC tag, last byte address, stride and
// confidence state. Reads are combinational, writes take effect at the
// clock edge. Reset clears only the valid bits; data fields are don't-care
// while invalid.
module pfs_table
    import pfs_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [PC_W-1:0]   rd_pc,
    output logic [ADDR_W-1:0] rd_last,
    output logic [ADDR_W-1:0] rd_stride,
    output conf_e             rd_state,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [ADDR_W-1:0] wr_last,
    input  logic [ADDR_W-1:0] wr_stride,
    input  conf_e             wr_state
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [PC_W-1:0]    pc_q     [ENTRIES];
    logic [ADDR_W-1:0]  last_q   [ENTRIES];
    logic [ADDR_W-1:0]  stride_q [ENTRIES];
    conf_e              state_q  [ENTRIES];

    // Purpose: clear valid bits on reset, otherwise write the selected entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx]  <= 1'b1;
            pc_q[wr_idx]     <= wr_pc;
            last_q[wr_idx]   <= wr_last;
            stride_q[wr_idx] <= wr_stride;
            state_q[wr_idx]  <= wr_state;
        end
    end

    // Purpose: present the addressed entry to the training logic.
    always_comb begin
        rd_valid  = valid_q[rd_idx];
        rd_pc     = pc_q[rd_idx];
        rd_last   = last_q[rd_idx];
        rd_stride = stride_q[rd_idx];
        rd_state  = state_q[rd_idx];
    end

endmodule

// File: rtl/pfs_train.sv
// Module: confidence and stride update for one looked-up entry.
// Purely combinational. On a tag miss it produces a fresh entry (stride 0,
// initial state); on a hit it compares the new delta with the stored stride.
module pfs_train
    import pfs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              hit,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] old_last,
    input  logic [ADDR_W-1:0] old_stride,
    input  conf_e             old_state,
    output logic [ADDR_W-1:0] nx_stride,
    output conf_e             nx_state
);

    logic [ADDR_W-1:0] delta;
    logic              match;

    // Purpose: difference between this address and the previous one.
    always_comb begin
        delta = cur_addr - old_last;
        match = (delta == old_stride);
    end

    // Purpose: next confidence state and stride per the transition table.
    always_comb begin
        nx_stride = old_stride;
        nx_state  = old_state;
        if (!hit) begin
            nx_stride = '0;
            nx_state  = ST_INIT;
        end else begin
            unique case (old_state)
                ST_INIT: begin
                    nx_state = match ? ST_STEADY : ST_TRANS;
                    if (!match) nx_stride = delta;
                end
                ST_TRANS: begin
                    nx_state = match ? ST_STEADY : ST_NOPRED;
                    if (!match) nx_stride = delta;
                end
                ST_STEADY: begin
                    nx_state = match ? ST_STEADY : ST_INIT;
                end
                ST_NOPRED: begin
                    nx_state = match ? ST_TRANS : ST_NOPRED;
                    if (!match) nx_stride = delta;
                end
                default: begin
                    nx_state = ST_INIT;
                end
            endcase
        end
    end

endmodule

// File: rtl/pfs_issue.sv
// Module: prefetch issue filter and output register.
// Forms the target line, rejects zero stride, same-line and duplicate
// targets, enforces the fill-buffer reserve, and registers the request.
// Assumes the caller asserts cand only for a steady entry on a valid load.
module pfs_issue #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int FB_W   = 4,
    parameter int FB_MIN = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cand,
    input  logic [ADDR_W-1:0]       cur_addr,
    input  logic [ADDR_W-1:0]       stride,
    input  logic [FB_W-1:0]         fb_free,
    input  logic                    ld_miss,
    output logic                    pf_valid,
    output logic [ADDR_W-OFF_W-1:0] pf_line
);

    localparam int              LINE_W = ADDR_W - OFF_W;
    localparam logic [FB_W:0]   MIN_V  = FB_MIN[FB_W:0];

    logic [ADDR_W-1:0] tgt_addr;
    logic [LINE_W-1:0] tgt_line;
    logic [LINE_W-1:0] cur_line;
    logic [FB_W:0]     need;
    logic              budget_ok;
    logic              dup;
    logic              fire;
    logic              lpf_v;
    logic [LINE_W-1:0] lpf_q;

    // Purpose: compute target and current line addresses.
    always_comb begin
        tgt_addr = cur_addr + stride;
        tgt_line = tgt_addr[ADDR_W-1:OFF_W];
        cur_line = cur_addr[ADDR_W-1:OFF_W];
    end

    // Purpose: reserve check, free buffers must cover the minimum plus a miss.
    always_comb begin
        need      = MIN_V + {{FB_W{1'b0}}, ld_miss};
        budget_ok = ({1'b0, fb_free} >= need);
    end

    // Purpose: final issue decision.
    always_comb begin
        dup  = lpf_v && (tgt_line == lpf_q);
        fire = cand && (stride != '0) && (tgt_line != cur_line) && !dup && budget_ok;
    end

    // Purpose: register the request and remember the last issued line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_line  <= '0;
            lpf_v    <= 1'b0;
            lpf_q    <= '0;
        end else begin
            pf_valid <= fire;
            if (fire) begin
                pf_line <= tgt_line;
                lpf_q   <= tgt_line;
                lpf_v   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pfs_prefetcher.sv
// Module: top of the per-instruction stride prefetcher.
// Looks up the table by PC bits, updates the entry on every valid load,
// and hands steady entries to the issue filter. Output is registered:
// a request appears the cycle after its triggering load.
module pfs_prefetcher
    import pfs_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int PC_LSB = 2,
    parameter int OFF_W  = 6,
    parameter int FB_W   = 4,
    parameter int FB_MIN = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_valid,
    input  logic [PC_W-1:0]         ld_pc,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic                    ld_miss,
    input  logic [FB_W-1:0]         fb_free,
    output logic                    pf_valid,
    output logic [ADDR_W-OFF_W-1:0] pf_line
);

    logic [IDX_W-1:0]  idx;
    logic              rd_valid;
    logic [PC_W-1:0]   rd_pc;
    logic [ADDR_W-1:0] rd_last;
    logic [ADDR_W-1:0] rd_stride;
    conf_e             rd_state;
    logic              hit;
    logic [ADDR_W-1:0] nx_stride;
    conf_e             nx_state;
    logic              cand;

    // Purpose: select the entry from the PC bits above the instruction offset.
    always_comb begin
        idx = ld_pc[PC_LSB +: IDX_W];
        hit = rd_valid && (rd_pc == ld_pc);
    end

    pfs_table #(
        .IDX_W (IDX_W),
        .PC_W  (PC_W),
        .ADDR_W(ADDR_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .rd_valid (rd_valid),
        .rd_pc    (rd_pc),
        .rd_last  (rd_last),
        .rd_stride(rd_stride),
        .rd_state (rd_state),
        .wr_en    (ld_valid),
        .wr_idx   (idx),
        .wr_pc    (ld_pc),
        .wr_last  (ld_addr),
        .wr_stride(nx_stride),
        .wr_state (nx_state)
    );

    pfs_train #(
        .ADDR_W(ADDR_W)
    ) u_train (
        .hit       (hit),
        .cur_addr  (ld_addr),
        .old_last  (rd_last),
        .old_stride(rd_stride),
        .old_state (rd_state),
        .nx_stride (nx_stride),
        .nx_state  (nx_state)
    );

    // Purpose: only confirmed patterns on a real load are issue candidates.
    always_comb begin
        cand = ld_valid && hit && (nx_state == ST_STEADY);
    end

    pfs_issue #(
        .ADDR_W(ADDR_W),
        .OFF_W (OFF_W),
        .FB_W  (FB_W),
        .FB_MIN(FB_MIN)
    ) u_issue (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand    (cand),
        .cur_addr(ld_addr),
        .stride  (nx_stride),
        .fb_free (fb_free),
        .ld_miss (ld_miss),
        .pf_valid(pf_valid),
        .pf_line (pf_line)
    );

endmodule

// File: rtl/pfs_checker.sv
// Module: temporal checks on the prefetcher ports, bound to the top.
// Assumes a synchronous active-low reset.
module pfs_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int FB_W   = 4,
    parameter int FB_MIN = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ld_valid,
    input logic [ADDR_W-1:0]       ld_addr,
    input logic                    ld_miss,
    input logic [FB_W-1:0]         fb_free,
    input logic                    pf_valid,
    input logic [ADDR_W-OFF_W-1:0] pf_line
);

    logic [ADDR_W-1:0] ld_line_ext;
    logic [ADDR_W-1:0] pf_line_ext;
    logic [FB_W+1:0]   avail_plus;

    // Purpose: widen line addresses and buffer counts for comparison.
    always_comb begin
        ld_line_ext = ld_addr >> OFF_W;
        pf_line_ext = {{OFF_W{1'b0}}, pf_line};
        avail_plus  = {2'b00, fb_free};
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !pf_valid);

    // R10
    no_load_no_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !pf_valid);

    // R8
    reserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (avail_plus < FB_MIN + {{(FB_W+1){1'b0}}, ld_miss})) |=> !pf_valid);

    // R7
    not_own_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (!pf_valid || (pf_line_ext != $past(ld_line_ext))));

    // R9
    no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |=> (!pf_valid || (pf_line != $past(pf_line))));

endmodule

bind pfs_prefetcher pfs_checker #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .FB_W  (FB_W),
    .FB_MIN(FB_MIN)
) u_pfs_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_valid(ld_valid),
    .ld_addr (ld_addr),
    .ld_miss (ld_miss),
    .fb_free (fb_free),
    .pf_valid(pf_valid),
    .pf_line (pf_line)
);

// File: tb/pfs_prefetcher_bench.sv
// Bench: directed corner cases followed by seeded random traffic, each
// cycle compared with a reference model built from the requirements.
module pfs_prefetcher_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_pc = '0;
    logic [31:0] ld_addr = '0;
    logic        ld_miss = 1'b0;
    logic [3:0]  fb_free = 4'd8;
    logic        pf_valid;
    logic [25:0] pf_line;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // model state (states: 0 init, 1 transient, 2 steady, 3 no-pred)
    bit          m_v   [16];
    logic [31:0] m_pc  [16];
    logic [31:0] m_last[16];
    logic [31:0] m_str [16];
    int          m_st  [16];
    bit          m_pfv;
    logic [25:0] m_pf;

    always #10 clk = ~clk;  // 50 MHz

    pfs_prefetcher u_pfs_prefetcher (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
        .ld_addr(ld_addr), .ld_miss(ld_miss), .fb_free(fb_free),
        .pf_valid(pf_valid), .pf_line(pf_line)
    );

    function automatic int next_state(int s, bit match);
        case (s)
            0: return match ? 2 : 1;
            1: return match ? 2 : 3;
            2: return match ? 2 : 0;
            default: return match ? 1 : 3;
        endcase
    endfunction

    function automatic logic [25:0] line_of(logic [31:0] a);
        return a[31:6];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
        m_pfv = 1'b0;
        m_pf  = '0;
    endtask

    // Drive one cycle (called at a negedge), then compare at the next negedge.
    task automatic step(bit v, logic [31:0] pc, logic [31:0] a, bit miss,
                        int free, string tag);
        bit          exp_v = 1'b0;
        logic [25:0] exp_l = '0;
        int          ix;
        ld_valid = v; ld_pc = pc; ld_addr = a; ld_miss = miss;
        fb_free  = 4'(free);
        ix = int'(pc[5:2]);
        if (v) begin
            if (!(m_v[ix] && m_pc[ix] == pc)) begin
                m_v[ix] = 1'b1; m_pc[ix] = pc; m_last[ix] = a;
                m_str[ix] = '0; m_st[ix] = 0;
            end else begin
                logic [31:0] d;
                bit          mt;
                int          ns;
                d  = a - m_last[ix];
                mt = (d == m_str[ix]);
                ns = next_state(m_st[ix], mt);
                if (!mt && m_st[ix] != 2) m_str[ix] = d;
                m_st[ix] = ns;
                m_last[ix] = a;
                if (ns == 2 && m_str[ix] != 0) begin
                    logic [25:0] tl;
                    tl = line_of(a + m_str[ix]);
                    if (tl != line_of(a) && !(m_pfv && tl == m_pf)
                        && free >= 3 + int'(miss)) begin
                        exp_v = 1'b1; exp_l = tl;
                        m_pfv = 1'b1; m_pf = tl;
                    end
                end
            end
        end
        @(negedge clk);
        vectors++;
        if (pf_valid !== exp_v || (exp_v && pf_line !== exp_l)) begin
            miscompares++;
            $display("FAIL %s: pf_valid=%0b pf_line=%h expected pf_valid=%0b pf_line=%h",
                     tag, pf_valid, pf_line, exp_v, exp_l);
        end
    endtask

    task automatic ld(logic [31:0] pc, logic [31:0] a, string tag);
        step(1'b1, pc, a, 1'b0, 8, tag);
    endtask

    // Watchdog: an expired run is a miscompare and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] pcs [6];
        logic [31:0] cur [6];
        logic [31:0] str [6];
        void'($urandom(32'd24681));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        step(1'b0, 32'h0, 32'h0, 1'b0, 8, "R1 idle after reset");
        // R1 / R2: first load of a PC allocates only
        ld(32'h1000, 32'h0001_0000, "R1 first load");
        ld(32'h1000, 32'h0001_0040, "R3 transient");
        ld(32'h1000, 32'h0001_0080, "R3 steady issue");
        // R4: interleave PC at another index, negative stride
        ld(32'h2004, 32'h0002_0000, "R4 other alloc");
        ld(32'h1000, 32'h0001_00C0, "R4 stream A keeps issuing");
        ld(32'h2004, 32'h0001_FF80, "R4 other transient");
        ld(32'h1000, 32'h0001_0100, "R4 stream A");
        ld(32'h2004, 32'h0001_FF00, "R4 R7 negative stride issue");
        // R5: break then resume with kept stride
        ld(32'h1000, 32'h0005_0000, "R5 break no issue");
        ld(32'h1000, 32'h0005_0040, "R5 resume issue");
        // R2: alias at index 0 evicts, original relearns
        ld(32'h1040, 32'h0007_0000, "R2 alias alloc");
        ld(32'h1000, 32'h0005_0080, "R2 evicted PC realloc");
        ld(32'h1000, 32'h0005_00C0, "R2 relearn transient");
        ld(32'h1000, 32'h0005_0100, "R2 relearn issue");
        // R6: zero stride
        for (int i = 0; i < 4; i++) ld(32'h3008, 32'h0009_0010, "R6 zero stride");
        // R7: small stride crosses a line rarely
        for (int i = 0; i < 12; i++)
            ld(32'h400C, 32'h000A_0000 + 32'(i * 8), "R7 same-line suppression");
        // R9: two PCs walking one array
        for (int i = 0; i < 4; i++) begin
            ld(32'h5010, 32'h000C_0000 + 32'(i * 64), "R9 leader");
            ld(32'h5014, 32'h000C_0004 + 32'(i * 64), "R9 follower duplicate");
        end
        // R8: reserve boundary
        ld(32'h6018, 32'h000E_0000, "R8 train");
        ld(32'h6018, 32'h000E_0080, "R8 train");
        step(1'b1, 32'h6018, 32'h000E_0100, 1'b1, 3, "R8 miss with 3 free blocked");
        step(1'b1, 32'h6018, 32'h000E_0180, 1'b0, 2, "R8 2 free blocked");
        step(1'b1, 32'h6018, 32'h000E_0200, 1'b1, 4, "R8 miss with 4 free issues");
        step(1'b1, 32'h6018, 32'h000E_0280, 1'b0, 3, "R8 3 free issues");
        // R10: idle cycle between requests
        step(1'b0, 32'h6018, 32'h000E_0300, 1'b0, 8, "R10 no load");
        // R1: reset mid-run clears the table and duplicate record
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        ld(32'h6018, 32'h000E_0300, "R1 table cleared");
        // R10: random traffic
        pcs[0] = 32'h400; pcs[1] = 32'h404; pcs[2] = 32'h408;
        pcs[3] = 32'h40C; pcs[4] = 32'h500; pcs[5] = 32'h414;
        str[0] = 32'd64;  str[1] = -32'sd128; str[2] = 32'd8;
        str[3] = 32'd0;   str[4] = 32'd192;   str[5] = 32'd4096;
        for (int k = 0; k < 6; k++) cur[k] = $urandom() & 32'hFFFF_FFF8;
        for (int n = 0; n < 4000; n++) begin
            int k;
            k = int'($urandom_range(0, 5));
            if ($urandom_range(0, 9) == 0) begin
                step(1'b0, 32'h0, 32'h0, 1'b0, 8, "R10 idle");
            end else begin
                if ($urandom_range(0, 19) == 0) cur[k] = $urandom();
                else cur[k] = cur[k] + str[k];
                step(1'b1, pcs[k], cur[k], 1'($urandom_range(0, 1)),
                     int'($urandom_range(0, 12)), "R10 random");
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule